// File: doc/BRIEF.md
# Vector Mask Compress/Expand Unit

This unit moves elements between a sparse layout and a dense layout under the control of a one-bit-per-element mask. In pack mode it gathers every element whose mask bit is set and lays them down one after another from element 0 of the result. It also reports how many elements were packed. In unpack mode it performs the inverse. The dense elements are dealt out, in order, to the positions of the set mask bits. Every other position of the result takes its value from a background vector.

An operation is launched with a one-cycle `start_i` while the unit is idle. On that edge the unit captures the mode, the mask, the source vector, the background vector and the active length. The background vector also serves as the prior contents of the destination. The unit then visits one element per clock, from element 0 up to the active length minus one. When the last element has been visited, `done_o` pulses for one cycle. The result vector and the packed count hold until the next operation is accepted.

Top module: `vec_cmpx`

## Requirements
- R1: In pack mode (`mode_i`=0), destination element k equals the source element at the position of the k-th set mask bit below the active length, counted upward from element 0.
- R2: When `done_o` is high, `plen_o` equals the number of set mask bits below the active length.
- R3: In unpack mode (`mode_i`=1), the destination element at the position of the k-th set mask bit below the active length equals source element k.
- R4: In unpack mode, a destination element whose mask bit is clear equals the background element at the same position.
- R5: Mask bits at or above the active length have no effect, and destination elements at or above the active length equal the background.
- R6: In pack mode, destination elements at or above `plen_o` equal the background, which stands for the destination's earlier contents.
- R7: The unit processes one element per clock. `done_o` is first seen high exactly L clock edges after the edge that accepted `start_i`, where L is the active length (L=0 gives a pulse right after the accepting edge).
- R8: `done_o` lasts exactly one cycle and is never high together with `busy_o`. While no operation is accepted, `dst_o` and `plen_o` hold their values.
- R9: An all-zero mask gives `plen_o`=0 and a destination equal to the background, in both modes.
- R10: `start_i` is accepted only when both `busy_o` and `done_o` are low. A start during a running operation changes neither its result nor its timing.
- R11: The active length is `vlen_i` clamped to NELEM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch an operation (accepted only when idle) |
| mode_i | input | 1 | 0 = pack, 1 = unpack |
| vlen_i | input | $clog2(NELEM+1) | Requested active length |
| mask_i | input | NELEM | Element mask, bit i for element i |
| src_i | input | NELEM*DW | Source vector, element i at bits [i*DW +: DW] |
| bg_i | input | NELEM*DW | Background / prior destination vector |
| busy_o | output | 1 | Elements are being visited |
| done_o | output | 1 | One-cycle completion pulse |
| plen_o | output | $clog2(NELEM+1) | Packed element count |
| dst_o | output | NELEM*DW | Result vector, same layout as the source |

## Verification
The checker assumes a clean handshake. A start counts only when `busy_o` and `done_o` are both low. Its captured mask and length then describe the whole run, which is what its count and run-length properties depend on. The stimulus changes inputs only on falling edges and holds `start_i` for a single accepting cycle. The one deliberate exception is a second start raised while the unit is running. That start carries an inverted mask and the other mode, and it is there to show that a start during a run is discarded. Lengths of zero, lengths above NELEM, full masks and empty masks are all driven, so the clamping and the empty cases are reached.

// File: rtl/vcx_pkg.sv
package vcx_pkg;

    typedef enum logic {
        VCX_PACK   = 1'b0,
        VCX_UNPACK = 1'b1
    } vcx_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } vcx_state_e;

    // Operation descriptor captured when a start is accepted
    typedef struct packed {
        vcx_mode_e mode;
        logic      valid;
    } vcx_op_t;

endpackage

// File: rtl/vcx_seq.sv
module vcx_seq
    import vcx_pkg::*;
#(
    parameter int NELEM = 16,
    parameter int LW    = $clog2(NELEM + 1),
    parameter int IW    = $clog2(NELEM)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [LW-1:0] vlen_i,
    output logic          load_o,
    output logic          step_o,
    output logic [IW-1:0] idx_o,
    output logic          busy_o,
    output logic          done_o
);

    localparam logic [LW-1:0] LEN_CAP = LW'(NELEM);

    vcx_state_e    st_q;
    logic [IW-1:0] idx_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] len_eff;
    logic          accept;
    logic          at_last;

    assign len_eff = (vlen_i > LEN_CAP) ? LEN_CAP : vlen_i;
    assign accept  = start_i && (st_q == ST_IDLE);
    assign at_last = ((LW'(idx_q) + LW'(1)) == len_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
            len_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        idx_q <= '0;
                        len_q <= len_eff;
                        st_q  <= (len_eff == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (at_last) begin
                        st_q <= ST_FIN;
                    end else begin
                        idx_q <= idx_q + IW'(1);
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign load_o = accept;
    assign step_o = (st_q == ST_RUN);
    assign idx_o  = idx_q;
    assign busy_o = (st_q == ST_RUN);
    assign done_o = (st_q == ST_FIN);

endmodule

// File: rtl/vcx_cnt.sv
module vcx_cnt #(
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [LW-1:0] cnt_o
);

    logic [LW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + LW'(1);
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/vcx_store.sv
module vcx_store
    import vcx_pkg::*;
#(
    parameter int NELEM = 16,
    parameter int DW    = 16,
    parameter int IW    = $clog2(NELEM)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load_i,
    input  logic [NELEM*DW-1:0] src_i,
    input  logic [NELEM*DW-1:0] bg_i,
    input  logic                wr_i,
    input  vcx_mode_e           mode_i,
    input  logic [IW-1:0]       idx_i,
    input  logic [IW-1:0]       pidx_i,
    output logic [NELEM*DW-1:0] dst_o
);

    logic [DW-1:0] src_q [NELEM];
    logic [DW-1:0] dst_q [NELEM];
    logic [DW-1:0] src_e [NELEM];
    logic [DW-1:0] bg_e  [NELEM];

    for (genvar k = 0; k < NELEM; k++) begin : g_lane
        assign src_e[k]           = src_i[k*DW +: DW];
        assign bg_e[k]            = bg_i[k*DW +: DW];
        assign dst_o[k*DW +: DW]  = dst_q[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NELEM; k++) begin
                src_q[k] <= '0;
                dst_q[k] <= '0;
            end
        end else if (load_i) begin
            for (int k = 0; k < NELEM; k++) begin
                src_q[k] <= src_e[k];
                dst_q[k] <= bg_e[k];
            end
        end else if (wr_i) begin
            if (mode_i == VCX_PACK) begin
                dst_q[pidx_i] <= src_q[idx_i];
            end else begin
                dst_q[idx_i] <= src_q[pidx_i];
            end
        end
    end

endmodule

// File: rtl/vec_cmpx.sv
module vec_cmpx
    import vcx_pkg::*;
#(
    parameter int NELEM = 16,
    parameter int DW    = 16,
    localparam int LW   = $clog2(NELEM + 1),
    localparam int IW   = $clog2(NELEM)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                mode_i,
    input  logic [LW-1:0]       vlen_i,
    input  logic [NELEM-1:0]    mask_i,
    input  logic [NELEM*DW-1:0] src_i,
    input  logic [NELEM*DW-1:0] bg_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [LW-1:0]       plen_o,
    output logic [NELEM*DW-1:0] dst_o
);

    logic             load;
    logic             step;
    logic [IW-1:0]    idx;
    logic [LW-1:0]    pcnt;
    logic [NELEM-1:0] mask_q;
    vcx_op_t          op_q;
    logic             hit;

    vcx_seq #(.NELEM(NELEM), .LW(LW), .IW(IW)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start_i(start_i),
        .vlen_i (vlen_i),
        .load_o (load),
        .step_o (step),
        .idx_o  (idx),
        .busy_o (busy_o),
        .done_o (done_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            op_q   <= '{mode: VCX_PACK, valid: 1'b0};
        end else if (load) begin
            mask_q <= mask_i;
            op_q   <= '{mode: vcx_mode_e'(mode_i), valid: 1'b1};
        end
    end

    assign hit = step && op_q.valid && mask_q[idx];

    vcx_cnt #(.LW(LW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr_i(load),
        .inc_i(hit),
        .cnt_o(pcnt)
    );

    vcx_store #(.NELEM(NELEM), .DW(DW), .IW(IW)) u_store (
        .clk   (clk),
        .rst   (rst),
        .load_i(load),
        .src_i (src_i),
        .bg_i  (bg_i),
        .wr_i  (hit),
        .mode_i(op_q.mode),
        .idx_i (idx),
        .pidx_i(pcnt[IW-1:0]),
        .dst_o (dst_o)
    );

    assign plen_o = pcnt;

endmodule

// File: rtl/vcx_chk.sv
module vcx_chk #(
    parameter int NELEM = 16,
    parameter int DW    = 16,
    parameter int LW    = $clog2(NELEM + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic                start_i,
    input logic [LW-1:0]       vlen_i,
    input logic [NELEM-1:0]    mask_i,
    input logic                busy_o,
    input logic                done_o,
    input logic [LW-1:0]       plen_o,
    input logic [NELEM*DW-1:0] dst_o
);

    logic [NELEM-1:0] cap_mask;
    logic [LW-1:0]    cap_len;
    logic [LW-1:0]    run_cnt;
    logic [LW-1:0]    req_len;
    logic [NELEM-1:0] len_bits;
    logic             took;

    assign took    = start_i && !busy_o && !done_o;
    assign req_len = (vlen_i > LW'(NELEM)) ? LW'(NELEM) : vlen_i;

    always_comb begin
        for (int k = 0; k < NELEM; k++) begin
            len_bits[k] = (k < int'(req_len));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_mask <= '0;
            cap_len  <= '0;
            run_cnt  <= '0;
        end else if (took) begin
            cap_mask <= mask_i & len_bits;
            cap_len  <= req_len;
            run_cnt  <= '0;
        end else if (busy_o) begin
            run_cnt  <= run_cnt + LW'(1);
        end
    end

    // R2, R5: count matches the set bits below the active length
    a_r2_plen_popcount: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (int'(plen_o) == $countones(cap_mask)));

    // R7: number of busy cycles equals the active length
    a_r7_run_length: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (run_cnt == cap_len));

    // R8: single-cycle completion pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8: completion and activity never overlap
    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R8: results hold while nothing runs or starts
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !took) |=> ($stable(dst_o) && $stable(plen_o)));

    // R11: the count never exceeds the clamped length
    a_r11_plen_bound: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (plen_o <= cap_len));

endmodule

bind vec_cmpx vcx_chk #(.NELEM(NELEM), .DW(DW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .vlen_i (vlen_i),
    .mask_i (mask_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .plen_o (plen_o),
    .dst_o  (dst_o)
);

// File: tb/vec_cmpx_tb.sv
module vec_cmpx_tb;

    localparam int NELEM = 16;
    localparam int DW    = 16;
    localparam int LW    = $clog2(NELEM + 1);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start_i = 1'b0;
    logic                mode_i = 1'b0;
    logic [LW-1:0]       vlen_i = '0;
    logic [NELEM-1:0]    mask_i = '0;
    logic [NELEM*DW-1:0] src_i = '0;
    logic [NELEM*DW-1:0] bg_i = '0;
    logic                busy_o;
    logic                done_o;
    logic [LW-1:0]       plen_o;
    logic [NELEM*DW-1:0] dst_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    vec_cmpx #(.NELEM(NELEM), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .vlen_i(vlen_i), .mask_i(mask_i), .src_i(src_i), .bg_i(bg_i),
        .busy_o(busy_o), .done_o(done_o), .plen_o(plen_o), .dst_o(dst_o)
    );

    task automatic check(input bit ok, input string req, input logic [NELEM*DW-1:0] act,
                         input logic [NELEM*DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] seed);
        for (int k = 0; k < NELEM; k++) begin
            src_i[k*DW +: DW] = {seed, 8'(k)};
            bg_i[k*DW +: DW]  = {~seed, 8'(k)};
        end
    endtask

    // Reference built from the requirements text
    task automatic model(input bit md, input logic [NELEM-1:0] m, input int req,
                         output logic [NELEM*DW-1:0] exp, output int cnt);
        int lim;
        lim = (req > NELEM) ? NELEM : req;
        exp = bg_i;
        cnt = 0;
        for (int k = 0; k < lim; k++) begin
            if (m[k]) begin
                if (!md) exp[cnt*DW +: DW] = src_i[k*DW +: DW];
                else     exp[k*DW +: DW]   = src_i[cnt*DW +: DW];
                cnt++;
            end
        end
    endtask

    task automatic run_op(input bit md, input logic [NELEM-1:0] m, input int req,
                          input bit poke, input string tag);
        logic [NELEM*DW-1:0] exp;
        int cnt, n, lim;
        lim = (req > NELEM) ? NELEM : req;
        model(md, m, req, exp, cnt);
        @(negedge clk);
        mode_i  = md;
        mask_i  = m;
        vlen_i  = LW'(req);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 200) begin
            if (poke) begin
                start_i = (n == 2);
                mask_i  = (n == 2) ? ~m : m;
                mode_i  = (n == 2) ? ~md : md;
            end
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        mask_i  = m;
        mode_i  = md;
        check(n == lim, $sformatf("R7 latency %s", tag), NELEM*DW'(n), NELEM*DW'(lim));
        check(!busy_o, $sformatf("R8 busy at done %s", tag), NELEM*DW'(busy_o), '0);
        check(int'(plen_o) == cnt, $sformatf("R2 count %s", tag),
              NELEM*DW'(plen_o), NELEM*DW'(cnt));
        check(dst_o == exp, $sformatf("%s result", tag), dst_o, exp);
        @(posedge clk);
        @(negedge clk);
        check(!done_o, $sformatf("R8 pulse width %s", tag), NELEM*DW'(done_o), '0);
        check(dst_o == exp && int'(plen_o) == cnt, $sformatf("R8 hold %s", tag), dst_o, exp);
    endtask

    task automatic t_reset();
        check(!busy_o && !done_o && plen_o == '0 && dst_o == '0, "reset state",
              dst_o, '0);
    endtask

    task automatic t_pack_basic();
        fill(8'hA1);
        run_op(1'b0, 16'hA5C3, 16, 1'b0, "R1 pack order");
        fill(8'hB2);
        run_op(1'b0, 16'h8001, 16, 1'b0, "R1 R6 pack sparse");
    endtask

    task automatic t_unpack_basic();
        fill(8'hC3);
        run_op(1'b1, 16'hA5C3, 16, 1'b0, "R3 R4 unpack");
        fill(8'hC4);
        run_op(1'b1, 16'h7FFE, 16, 1'b0, "R3 R4 unpack dense");
    endtask

    task automatic t_length_limit();
        fill(8'hD5);
        run_op(1'b0, 16'hFFFF, 10, 1'b0, "R5 R6 pack short length");
        fill(8'hD6);
        run_op(1'b1, 16'hF0F0, 6, 1'b0, "R5 unpack short length");
    endtask

    task automatic t_empty();
        fill(8'hE7);
        run_op(1'b1, 16'h0000, 16, 1'b0, "R9 unpack empty mask");
        run_op(1'b0, 16'h0000, 16, 1'b0, "R9 pack empty mask");
        run_op(1'b0, 16'hFFFF, 0, 1'b0, "R7 zero length");
    endtask

    task automatic t_clamp();
        fill(8'h3C);
        run_op(1'b0, 16'h5AA5, 20, 1'b0, "R11 length clamp");
    endtask

    task automatic t_busy_start();
        fill(8'h69);
        run_op(1'b0, 16'h0F35, 12, 1'b1, "R10 start while busy");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pack_basic();
        t_unpack_basic();
        t_length_limit();
        t_empty();
        t_clamp();
        t_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule